// File: doc/BRIEF.md
# External-Request DMA Channel Sequencer

This block serves several DMA channels that are started by request lines from outside the chip. Each channel has its own transfer count, block size, transfer mode, reload flag, access-locality flag, strobe direction, address-increment flag, destination address and two output-enable bits. These all arrive on plain input ports. The sequencer picks one channel at a time by fixed priority and drives a single fly-by bus cycle for each data item. A bus cycle is one address-phase cycle followed by one strobe cycle. For each item the block presents the destination address together with a per-channel acknowledge. The external I/O device decodes that acknowledge with the read or write strobe and needs no address of its own.

A request line passes through a two-flop synchronizer before it is used. Burst, step and block modes act on the rising edge of the synchronized request. Demand mode acts on its level. The end-of-operation output marks the final item of a channel's programmed work, but only when that item goes to the external bus. The sequencer holds the active channel for a whole block and runs arbitration again only when the block ends. While the final transfer is in its acknowledge phase, the channel can already accept its next request.

Top module: `dmas_seq`

## Requirements
- R1: When the sequencer is idle, the lowest-numbered channel with work pending is served first. Requests raised in the same cycle on channels 0 and 1 produce acknowledges in the order 0,0,1,1 for two-item bursts.
- R2: Burst mode (mode code 0): one accepted request performs all `count` items back to back. End-of-operation fires on the last strobe only.
- R3: Step mode (mode code 1): each accepted request performs exactly one item. End-of-operation fires on the item numbered `count`.
- R4: Block mode (mode code 2): `count` blocks of `blk_size` items are performed. End-of-operation fires only on the last item of the last block.
- R5: In block mode the channel is held for every item inside a block. Pending requests are evaluated again only at a block boundary, and a higher-priority channel that requested mid-block is served there.
- R6: Demand mode (mode code 3): items are performed only while the synchronized request is high. Dropping the request pauses the work with the remaining count kept and no end-of-operation. Raising it again resumes the work.
- R7: In demand mode without reload, the channel stops at the end of its count even if the request stays high. It needs a low level before it restarts. With reload set, the count reloads and transfers continue while the request stays high, with one end-of-operation for every `count` items.
- R8: A request edge that arrives while the channel is being served is ignored and is not queued. The exception is an edge that arrives during the address phase of the final transfer: it queues exactly one further service.
- R9: Acknowledge is high only in the address phase and coincides with the address strobe `bus_as_o` for external channels. The following cycle drives `bus_rd_o` when `dir_rd_i` is 1 or `bus_wr_o` when it is 0. End-of-operation coincides with that strobe.
- R10: A channel whose `ext_i` bit is 0 drives no address strobe, no read or write strobe and no end-of-operation. Its acknowledge still appears.
- R11: Acknowledge and end-of-operation of a channel stay low while its `ack_en_i` or `eop_en_i` bit is 0. The bus cycles still run.
- R12: The bus address starts at the channel's destination address for a fresh operation. It increments by one per item when `addr_inc_i` is set and stays fixed otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NCH | Asynchronous transfer request per channel |
| mode_i | input | 2*NCH | Mode per channel: 0 burst, 1 step, 2 block, 3 demand |
| count_i | input | CNT_W*NCH | Items per operation (blocks in block mode); 0 is treated as 1 |
| blk_size_i | input | BLK_W*NCH | Items per block in block mode; 0 is treated as 1 |
| reload_i | input | NCH | Demand-mode count reload enable |
| ext_i | input | NCH | 1 = transfer uses the external bus |
| dir_rd_i | input | NCH | 1 = read strobe, 0 = write strobe |
| addr_inc_i | input | NCH | 1 = increment address per item |
| dst_addr_i | input | ADDR_W*NCH | Destination (memory) address per channel |
| ack_en_i | input | NCH | Acknowledge output enable |
| eop_en_i | input | NCH | End-of-operation output enable |
| ack_o | output | NCH | Acknowledge, address phase |
| eop_o | output | NCH | End-of-operation, strobe phase of the last item |
| bus_as_o | output | 1 | Address phase strobe |
| bus_addr_o | output | ADDR_W | Address during the address phase, else zero |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |

## Verification
A corrupted remaining-count or in-block counter is visible at the ports within one operation. It shows up as a wrong number of acknowledges, or as end-of-operation on the wrong strobe, on a block boundary or not at all. A pending flag set wrongly produces a whole extra burst or step after the channel has gone quiet, within a few cycles of the preceding end-of-operation. A held channel or arbitration done at the wrong moment changes the recorded order of acknowledges across channels at the first block boundary. A broken address register shows up in the address captured at the very first address strobe.

// File: rtl/dmas_pkg.sv
package dmas_pkg;
  typedef enum logic [1:0] {
    MODE_BURST  = 2'd0,
    MODE_STEP   = 2'd1,
    MODE_BLOCK  = 2'd2,
    MODE_DEMAND = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ADDR = 2'd1,
    SQ_STRB = 2'd2
  } sq_state_e;
endpackage

// File: rtl/dmas_req_sync.sv
module dmas_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic lvl_o,
  output logic rise_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], req_i};
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/dmas_prio_arb.sv
module dmas_prio_arb #(
  parameter int N     = 2,
  parameter int IDX_W = 1
) (
  input  logic [N-1:0]     want_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // fixed priority, index 0 highest
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (want_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmas_chan.sv
module dmas_chan
  import dmas_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              lvl_i,
  input  xfer_mode_e        mode_i,
  input  logic              reload_i,
  input  logic              active_i,
  input  logic              win_i,
  input  logic              svc_end_i,
  input  logic              done_i,
  input  logic [CNT_W-1:0]  wb_rem_i,
  input  logic [ADDR_W-1:0] wb_addr_i,
  output logic              want_o,
  output logic [CNT_W-1:0]  rem_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic pend_q, again_q, halted_q;
  logic [CNT_W-1:0]  rem_q;
  logic [ADDR_W-1:0] addr_q;
  logic edge_mode;

  assign edge_mode = (mode_i != MODE_DEMAND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      again_q  <= 1'b0;
      halted_q <= 1'b0;
      rem_q    <= '0;
      addr_q   <= '0;
    end else begin
      if (rise_i && edge_mode) begin
        if (!active_i)  pend_q  <= 1'b1;
        else if (win_i) again_q <= 1'b1;  // final-transfer window
      end
      if (svc_end_i) begin
        rem_q  <= wb_rem_i;
        addr_q <= wb_addr_i;
        if (done_i || mode_i == MODE_STEP) begin
          pend_q  <= again_q;
          again_q <= 1'b0;
        end
        if (done_i && mode_i == MODE_DEMAND && !reload_i) halted_q <= 1'b1;
      end else if (!lvl_i) begin
        halted_q <= 1'b0;
      end
    end
  end

  assign want_o = edge_mode ? pend_q : (lvl_i & ~halted_q);
  assign rem_o  = rem_q;
  assign addr_o = addr_q;

  AST_BUSY_EDGE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && active_i && !win_i && !svc_end_i) |=> ($stable(pend_q) && $stable(again_q))); // R8
endmodule

// File: rtl/dmas_seq.sv
module dmas_seq
  import dmas_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int CNT_W       = 8,
  parameter int BLK_W       = 4,
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NCH-1:0]        req_i,
  input  logic [2*NCH-1:0]      mode_i,
  input  logic [CNT_W*NCH-1:0]  count_i,
  input  logic [BLK_W*NCH-1:0]  blk_size_i,
  input  logic [NCH-1:0]        reload_i,
  input  logic [NCH-1:0]        ext_i,
  input  logic [NCH-1:0]        dir_rd_i,
  input  logic [NCH-1:0]        addr_inc_i,
  input  logic [ADDR_W*NCH-1:0] dst_addr_i,
  input  logic [NCH-1:0]        ack_en_i,
  input  logic [NCH-1:0]        eop_en_i,
  output logic [NCH-1:0]        ack_o,
  output logic [NCH-1:0]        eop_o,
  output logic                  bus_as_o,
  output logic [ADDR_W-1:0]     bus_addr_o,
  output logic                  bus_rd_o,
  output logic                  bus_wr_o
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  sq_state_e          st_q;
  logic [IDX_W-1:0]   cur_q;
  xfer_mode_e         cur_mode_q;
  logic [CNT_W-1:0]   cur_rem_q;
  logic [BLK_W-1:0]   cur_bi_q;
  logic [ADDR_W-1:0]  cur_addr_q;

  logic [NCH-1:0]     lvl, rise, want, active, win, svc_end_v, done_v;
  xfer_mode_e         mode_a [NCH];
  logic [CNT_W-1:0]   cnt_a  [NCH];
  logic [BLK_W-1:0]   blk_a  [NCH];
  logic [ADDR_W-1:0]  dst_a  [NCH];
  logic [CNT_W-1:0]   rem_a  [NCH];
  logic [ADDR_W-1:0]  addr_a [NCH];

  logic               item_last, blk_edge, seg_last, svc_end;
  logic [CNT_W-1:0]   nxt_rem, wb_rem;
  logic [ADDR_W-1:0]  nxt_addr;
  logic [IDX_W-1:0]   g_idx;
  logic               g_any, fresh, cur_ext;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign mode_a[i] = xfer_mode_e'(mode_i[2*i +: 2]);
    assign cnt_a[i]  = (count_i[CNT_W*i +: CNT_W] == '0) ? CNT_W'(1) : count_i[CNT_W*i +: CNT_W];
    assign blk_a[i]  = (blk_size_i[BLK_W*i +: BLK_W] == '0) ? BLK_W'(1) : blk_size_i[BLK_W*i +: BLK_W];
    assign dst_a[i]  = dst_addr_i[ADDR_W*i +: ADDR_W];

    assign active[i]    = (st_q != SQ_IDLE) && (cur_q == IDX_W'(i));
    assign win[i]       = active[i] && (st_q == SQ_ADDR) && seg_last;
    assign svc_end_v[i] = svc_end && (cur_q == IDX_W'(i));
    assign done_v[i]    = item_last;

    assign ack_o[i] = active[i] && (st_q == SQ_ADDR) && ack_en_i[i];
    assign eop_o[i] = active[i] && (st_q == SQ_STRB) && item_last && ext_i[i] && eop_en_i[i];

    dmas_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req_i[i]),
      .lvl_o  (lvl[i]),
      .rise_o (rise[i])
    );

    dmas_chan #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rise_i    (rise[i]),
      .lvl_i     (lvl[i]),
      .mode_i    (mode_a[i]),
      .reload_i  (reload_i[i]),
      .active_i  (active[i]),
      .win_i     (win[i]),
      .svc_end_i (svc_end_v[i]),
      .done_i    (done_v[i]),
      .wb_rem_i  (wb_rem),
      .wb_addr_i (nxt_addr),
      .want_o    (want[i]),
      .rem_o     (rem_a[i]),
      .addr_o    (addr_a[i])
    );
  end

  dmas_prio_arb #(.N(NCH), .IDX_W(IDX_W)) u_arb (
    .want_i (want),
    .idx_o  (g_idx),
    .any_o  (g_any)
  );

  assign item_last = (cur_bi_q == BLK_W'(1)) && (cur_rem_q == CNT_W'(1));
  assign blk_edge  = (cur_bi_q == BLK_W'(1));
  assign seg_last  = item_last || (cur_mode_q == MODE_STEP);
  // burst keeps the channel to the end; other modes yield at each unit boundary
  assign svc_end   = (st_q == SQ_STRB) && (item_last || (blk_edge && cur_mode_q != MODE_BURST));
  assign nxt_rem   = blk_edge ? cur_rem_q - CNT_W'(1) : cur_rem_q;
  assign wb_rem    = item_last ? '0 : nxt_rem;
  assign nxt_addr  = addr_inc_i[cur_q] ? cur_addr_q + ADDR_W'(1) : cur_addr_q;
  assign fresh     = (rem_a[g_idx] == '0);
  assign cur_ext   = ext_i[cur_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SQ_IDLE;
      cur_q      <= '0;
      cur_mode_q <= MODE_BURST;
      cur_rem_q  <= '0;
      cur_bi_q   <= '0;
      cur_addr_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (g_any) begin
          cur_q      <= g_idx;
          cur_mode_q <= mode_a[g_idx];
          cur_rem_q  <= fresh ? cnt_a[g_idx] : rem_a[g_idx];
          cur_addr_q <= fresh ? dst_a[g_idx] : addr_a[g_idx];
          cur_bi_q   <= (mode_a[g_idx] == MODE_BLOCK) ? blk_a[g_idx] : BLK_W'(1);
          st_q       <= SQ_ADDR;
        end
        SQ_ADDR: st_q <= SQ_STRB;
        SQ_STRB: begin
          cur_addr_q <= nxt_addr;
          if (svc_end) begin
            st_q <= SQ_IDLE;
          end else begin
            st_q      <= SQ_ADDR;
            cur_rem_q <= nxt_rem;
            cur_bi_q  <= blk_edge ? BLK_W'(1) : cur_bi_q - BLK_W'(1);
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign bus_as_o   = (st_q == SQ_ADDR) && cur_ext;
  assign bus_addr_o = bus_as_o ? cur_addr_q : '0;
  assign bus_rd_o   = (st_q == SQ_STRB) && cur_ext && dir_rd_i[cur_q];
  assign bus_wr_o   = (st_q == SQ_STRB) && cur_ext && !dir_rd_i[cur_q];

  AST_PRIO_CH0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_IDLE && want[0]) |=> (st_q == SQ_ADDR && cur_q == '0)); // R1
  AST_BLOCK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_STRB && !svc_end) |=> (st_q == SQ_ADDR && $stable(cur_q))); // R5
  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o)); // R9
  AST_ACK_WITH_AS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ack_o & ext_i)) |-> bus_as_o); // R9
  AST_STRB_AFTER_AS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o || bus_wr_o) |-> $past(bus_as_o)); // R9
  AST_EOP_ON_STRB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|eop_o) |-> (bus_rd_o || bus_wr_o)); // R10
  AST_INT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != SQ_IDLE && !cur_ext) |-> !(bus_as_o || bus_rd_o || bus_wr_o || (|eop_o))); // R10
endmodule

// File: tb/dmas_seq_tb.sv
module dmas_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2, CNT_W = 8, BLK_W = 4, ADDR_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] req = '0, reload = '0, ext = '0, dir_rd = '0, inc = '0, aen = '0, een = '0;
  logic [2*NCH-1:0] mode = '0;
  logic [CNT_W*NCH-1:0] cnt = '0;
  logic [BLK_W*NCH-1:0] blk = '0;
  logic [ADDR_W*NCH-1:0] dst = '0;
  logic [NCH-1:0] ack, eop;
  logic as_s, rd_s, wr_s;
  logic [ADDR_W-1:0] addr;

  int n_chk = 0, n_fail = 0;
  int n_ack [NCH];
  int n_eop [NCH];
  int n_as, n_rd, n_wr, eop_pos, n_ord;
  int ord [64];
  int alog [16];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmas_seq #(.NCH(NCH), .CNT_W(CNT_W), .BLK_W(BLK_W), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mode_i(mode), .count_i(cnt),
    .blk_size_i(blk), .reload_i(reload), .ext_i(ext), .dir_rd_i(dir_rd),
    .addr_inc_i(inc), .dst_addr_i(dst), .ack_en_i(aen), .eop_en_i(een),
    .ack_o(ack), .eop_o(eop), .bus_as_o(as_s), .bus_addr_o(addr),
    .bus_rd_o(rd_s), .bus_wr_o(wr_s)
  );

  always @(negedge clk) if (rst_n) begin
    for (int c = 0; c < NCH; c++) begin
      if (ack[c]) begin
        n_ack[c]++;
        if (n_ord < 64) ord[n_ord] = c;
        n_ord++;
      end
      if (eop[c]) begin
        n_eop[c]++;
        eop_pos = n_rd + n_wr + 1;
      end
    end
    if (as_s) begin
      if (n_as < 16) alog[n_as] = int'(addr);
      n_as++;
    end
    if (rd_s) n_rd++;
    if (wr_s) n_wr++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    @(posedge clk);
    for (int c = 0; c < NCH; c++) begin n_ack[c] = 0; n_eop[c] = 0; end
    n_as = 0; n_rd = 0; n_wr = 0; eop_pos = 0; n_ord = 0;
  endtask

  task automatic cfg(input int ch, input int m, input int c, input int b, input bit rl,
                     input bit ex, input bit rd, input bit in, input int d);
    mode[2*ch +: 2] = m[1:0];
    cnt[CNT_W*ch +: CNT_W] = c[CNT_W-1:0];
    blk[BLK_W*ch +: BLK_W] = b[BLK_W-1:0];
    dst[ADDR_W*ch +: ADDR_W] = d[ADDR_W-1:0];
    reload[ch] = rl; ext[ch] = ex; dir_rd[ch] = rd; inc[ch] = in;
    aen[ch] = 1'b1; een[ch] = 1'b1;
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    @(negedge clk); req = req | m;
    repeat (3) @(negedge clk);
    req = req & ~m;
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic wait_ack(input int ch, input int n);
    int k = 0;
    for (int t = 0; t < 300 && k < n; t++) begin
      @(negedge clk);
      if (ack[ch]) k++;
    end
    chk("wait_ack timeout", k, n);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 reset ack", int'(ack), 0);
    chk("R9 reset eop", int'(eop), 0);
    chk("R9 reset strobes", int'({as_s, rd_s, wr_s}), 0);
  endtask

  task automatic t_burst();
    cfg(0, 0, 4, 1, 0, 1, 1, 1, 'h100); clr();
    pulse(2'b01); settle();
    chk("R2 burst acks", n_ack[0], 4);
    chk("R2 burst eop count", n_eop[0], 1);
    chk("R2 burst eop position", eop_pos, 4);
    chk("R9 read strobes", n_rd, 4);
    chk("R9 no write strobes", n_wr, 0);
    chk("R12 first address", alog[0], 'h100);
    chk("R12 last address", alog[3], 'h103);
  endtask

  task automatic t_reassert();
    cfg(0, 0, 4, 1, 0, 1, 1, 1, 'h200); clr();
    pulse(2'b01); wait_ack(0, 2);
    req[0] = 1'b1; repeat (2) @(negedge clk); req[0] = 1'b0;
    settle();
    chk("R8 mid-burst edge ignored acks", n_ack[0], 4);
    chk("R8 mid-burst edge ignored eop", n_eop[0], 1);
    clr();
    pulse(2'b01); wait_ack(0, 2);
    repeat (2) @(negedge clk);
    req[0] = 1'b1; repeat (2) @(negedge clk); req[0] = 1'b0;
    settle();
    chk("R8 final-transfer edge queues one acks", n_ack[0], 8);
    chk("R8 final-transfer edge queues one eop", n_eop[0], 2);
  endtask

  task automatic t_step();
    cfg(1, 1, 3, 1, 0, 1, 0, 1, 'h300); clr();
    pulse(2'b10); settle();
    chk("R3 step one item", n_ack[1], 1);
    chk("R3 step no early eop", n_eop[1], 0);
    pulse(2'b10); settle(); pulse(2'b10); settle();
    chk("R3 step three items", n_ack[1], 3);
    chk("R3 step eop on last", n_eop[1], 1);
    chk("R9 write strobes", n_wr, 3);
  endtask

  task automatic t_block();
    cfg(1, 2, 2, 3, 0, 1, 0, 1, 'h400); clr();
    pulse(2'b10); settle();
    chk("R4 block items", n_ack[1], 6);
    chk("R4 block single eop", n_eop[1], 1);
    chk("R4 block eop on last item", eop_pos, 6);
  endtask

  task automatic t_block_arb();
    int exp_o [7] = '{1, 1, 1, 0, 1, 1, 1};
    int bad = 0;
    cfg(1, 2, 2, 3, 0, 1, 0, 1, 'h500);
    cfg(0, 1, 1, 1, 0, 1, 1, 1, 'h600); clr();
    pulse(2'b10); wait_ack(1, 1);
    pulse(2'b01); settle();
    chk("R5 total acks", n_ord, 7);
    for (int i = 0; i < 7; i++) if (ord[i] != exp_o[i]) bad++;
    chk("R5 order held in block, switch at boundary", bad, 0);
    chk("R5 step channel eop", n_eop[0], 1);
  endtask

  task automatic t_prio();
    cfg(0, 0, 2, 1, 0, 1, 1, 1, 'h700);
    cfg(1, 0, 2, 1, 0, 1, 1, 1, 'h800); clr();
    pulse(2'b11); settle();
    chk("R1 order count", n_ord, 4);
    chk("R1 order", ord[0]*1000 + ord[1]*100 + ord[2]*10 + ord[3], 11);
  endtask

  task automatic t_internal();
    cfg(0, 0, 2, 1, 0, 0, 1, 1, 'h900); clr();
    pulse(2'b01); settle();
    chk("R10 internal acks", n_ack[0], 2);
    chk("R10 internal no bus strobes", n_as + n_rd + n_wr, 0);
    chk("R10 internal no eop", n_eop[0], 0);
  endtask

  task automatic t_gating();
    cfg(0, 0, 2, 1, 0, 1, 1, 1, 'hA00); aen[0] = 1'b0; een[0] = 1'b0; clr();
    pulse(2'b01); settle();
    chk("R11 ack gated", n_ack[0], 0);
    chk("R11 eop gated", n_eop[0], 0);
    chk("R11 bus cycles still run", n_rd, 2);
    aen[0] = 1'b1; een[0] = 1'b1;
  endtask

  task automatic t_fixed();
    cfg(0, 0, 3, 1, 0, 1, 1, 0, 'h55); clr();
    pulse(2'b01); settle();
    chk("R12 fixed address first", alog[0], 'h55);
    chk("R12 fixed address last", alog[2], 'h55);
  endtask

  task automatic t_demand();
    int a;
    cfg(0, 3, 5, 1, 0, 1, 1, 1, 'hB00); clr();
    @(negedge clk); req[0] = 1'b1;
    wait_ack(0, 2);
    req[0] = 1'b0; settle();
    chk("R6 paused before count", int'(n_ack[0] < 5), 1);
    chk("R6 no eop on pause", n_eop[0], 0);
    req[0] = 1'b1; repeat (40) @(negedge clk);
    chk("R7 stops at count while held", n_ack[0], 5);
    chk("R6 eop after resume", n_eop[0], 1);
    req[0] = 1'b0; settle();
    reload[0] = 1'b1; clr();
    @(negedge clk); req[0] = 1'b1;
    repeat (45) @(negedge clk);
    req[0] = 1'b0; settle();
    a = n_ack[0];
    chk("R7 reload keeps running", int'(a >= 10), 1);
    chk("R7 eop per reloaded count", n_eop[0], a / 5);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin n_ack[c] = 0; n_eop[c] = 0; end
    n_as = 0; n_rd = 0; n_wr = 0; eop_pos = 0; n_ord = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_burst();
    t_reassert();
    t_step();
    t_block();
    t_block_arb();
    t_prio();
    t_internal();
    t_gating();
    t_fixed();
    t_demand();
    done = 1;
  end

  initial begin
    for (int t = 0; t < 100000 && !done; t++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule